// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a repeating down-counting timer for a host processor. Its interval is set by two 16-bit registers, a prescaler and a divider. The host can write each one as a full word or one byte lane at a time, and can read each one back.

After any write, the timer counts `(prescaler+1)*(divider+1)` tick pulses. When that count is used up, the block does three things: it raises a sticky pending flag, it issues a one-cycle interrupt request, and it reloads the same period so that interrupts repeat. A zero in either register stops the timer completely.

The counting rate comes from a one-cycle `tick` strobe, so a slow timebase can be shared across the chip.

Top module: `prescaled_timer`

## Requirements
- R1: While `rst_n` is low, both registers become 0, and `pending` and `irq` become 0.
- R2: A write with `wr_be`=2'b11 replaces the whole register. `wr_sel`=0 selects the prescaler and `wr_sel`=1 selects the divider. The other register is unchanged.
- R3: `wr_be[1]` updates bits 15:8 only and `wr_be[0]` updates bits 7:0 only. Unselected bytes keep their value.
- R4: `rd_data` combinationally shows the prescaler when `rd_sel`=0 and the divider when `rd_sel`=1.
- R5: With both registers nonzero, `irq` is high in the cycle right after the clock edge that takes the Nth tick following a write, where N=(prescaler+1)*(divider+1).
- R6: When either register is zero, `irq` never rises and `pending` never sets.
- R7: After an expiry the period reloads, so `irq` recurs every N ticks with no further write.
- R8: Any write strobe restarts the count from the new register values. The edge carrying the write takes no tick.
- R9: `pending` sets in the same edge as `irq` and holds until `irq_clr`. A new expiry wins over a clear in the same cycle.
- R10: `irq` lasts exactly one cycle. Cycles with `tick` low do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 prescaler, 1 divider |
| wr_be | input | 2 | Byte lane enables: bit1 high byte, bit0 low byte |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read select: 0 prescaler, 1 divider |
| rd_data | output | 16 | Selected register value |
| irq_clr | input | 1 | Clears the pending flag |
| pending | output | 1 | Sticky expiry flag |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench sweeps every prescaler and divider pair from 0 to 3 and measures the tick index of the first and second interrupt.

- An off-by-one in the product, or in the decrement, shifts that index.
- A missing reload loses the second interrupt.
- Treating zero as the shortest period produces interrupts where none are allowed.

Separate cases cover three further faults:
- Partial byte writes catch lane mixing.
- A mid-count rewrite catches a timer that ignores restarts and fires early.
- Gapped ticks catch a counter that runs on every clock.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [1:0]   wr_be,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         irq_clr,
  output logic         pending,
  output logic         irq
);
  localparam int H  = W / 2;
  localparam int CW = 2 * (W + 1);

  logic [W-1:0]  pre, div, tgt, merged, pre_nxt, div_nxt;
  logic [CW-1:0] cnt, period;
  logic          run, expire;

  assign tgt     = wr_sel ? div : pre;
  assign merged  = {wr_be[1] ? wr_data[W-1:H] : tgt[W-1:H],
                    wr_be[0] ? wr_data[H-1:0] : tgt[H-1:0]};
  assign pre_nxt = (wr_en && !wr_sel) ? merged : pre;
  assign div_nxt = (wr_en &&  wr_sel) ? merged : div;
  assign run     = (pre_nxt != '0) && (div_nxt != '0);
  assign period  = ({{(W+1){1'b0}}, 1'b0, pre_nxt} + 1'b1) *
                   ({{(W+1){1'b0}}, 1'b0, div_nxt} + 1'b1);
  assign expire  = !wr_en && tick && run && (cnt == CW'(1));
  assign rd_data = rd_sel ? div : pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      div     <= '0;
      cnt     <= '0;
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pre <= pre_nxt;
      div <= div_nxt;
      irq <= expire;
      if (expire)       pending <= 1'b1;
      else if (irq_clr) pending <= 1'b0;
      if (wr_en)
        cnt <= run ? period : '0;
      else if (expire)
        cnt <= period;
      else if (tick && run && cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic         irq_clr,
  input logic         irq,
  input logic         pending,
  input logic [W-1:0] pre,
  input logic [W-1:0] div
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq && !pending && pre == '0 && div == '0));

  assert_zero_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre == '0 || div == '0) |-> !irq);

  assert_write_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);

  assert_flag_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pending);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !irq_clr) |=> pending);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_tick_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq);
endmodule

bind prescaled_timer prescaled_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .irq_clr(irq_clr),
  .irq(irq), .pending(pending), .pre(pre), .div(div)
);

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;
  logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0, wr_sel = 0, rd_sel = 0, irq_clr = 0;
  logic [1:0]  wr_be = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic        pending, irq;
  int total = 0, bad = 0;

  prescaled_timer uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_be = 0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [15:0] exp);
    rd_sel = sel; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic clr();
    irq_clr = 1; @(posedge clk); @(negedge clk); irq_clr = 0;
  endtask

  task automatic run(input int maxn, input bit gapped, output int first, output int second);
    int n = 0, cyc = 0;
    bit prev = 0;
    first = 0; second = 0;
    while (n < maxn) begin
      logic t;
      t = !gapped || (cyc % 2 == 0);
      tick = t;
      @(posedge clk);
      if (t) n++;
      @(negedge clk);
      if (irq && prev) chk("R10 double pulse", 1, 0);
      if (irq) begin
        if (first == 0) first = n;
        else if (second == 0) second = n;
      end
      prev = irq;
      cyc++;
    end
    tick = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f, s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq", irq, 0);
    chk("R1 pending", pending, 0);
    rd("R1 prescaler", 0, 16'h0);
    rd("R1 divider", 1, 16'h0);

    wr(0, 2'b11, 16'hA5C3);
    rd("R2 prescaler word", 0, 16'hA5C3);
    rd("R2 divider untouched", 1, 16'h0);
    wr(1, 2'b11, 16'h1234);
    rd("R4 divider read", 1, 16'h1234);
    rd("R4 prescaler read", 0, 16'hA5C3);
    wr(0, 2'b10, 16'h77FF);
    rd("R3 high lane", 0, 16'h77C3);
    wr(0, 2'b01, 16'hEE11);
    rd("R3 low lane", 0, 16'h7711);
    rd("R3 other reg", 1, 16'h1234);

    for (int p = 0; p < 4; p++)
      for (int d = 0; d < 4; d++) begin
        int n;
        n = (p + 1) * (d + 1);
        wr(0, 2'b11, 16'(p));
        wr(1, 2'b11, 16'(d));
        clr();
        run(34, 0, f, s);
        if (p == 0 || d == 0) begin
          chk("R6 no irq", f, 0);
          chk("R6 no pending", pending, 0);
        end else begin
          chk("R5 first expiry", f, n);
          chk("R7 reload expiry", s, 2 * n);
          chk("R9 pending set", pending, 1);
        end
      end

    wr(0, 2'b11, 16'd1);
    wr(1, 2'b11, 16'd1);
    clr();
    run(4, 0, f, s);
    chk("R5 small period", f, 4);
    repeat (8) @(negedge clk);
    chk("R9 pending holds", pending, 1);
    clr();
    chk("R9 pending cleared", pending, 0);

    wr(0, 2'b11, 16'd1);
    run(8, 1, f, s);
    chk("R10 gapped ticks", f, 4);
    chk("R10 gapped reload", s, 8);

    wr(0, 2'b11, 16'd3);
    wr(1, 2'b11, 16'd3);
    run(10, 0, f, s);
    chk("R8 no early irq", f, 0);
    wr(1, 2'b11, 16'd3);
    run(16, 0, f, s);
    chk("R8 restart from write", f, 16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule